// File: doc/BRIEF.md
# Frequency-Limited Inverter Firing Sequencer

This block is the digital sequencer for a series inverter with two halves. One toggle bit picks the active half. That bit also drives the select line of the volt-second integrator's alternating switch, so the integrator and the inverter always step together. Each time the toggle changes state, the half that has just become active receives one firing pulse of fixed width. When the second rectifier pair is enabled, its outputs repeat the first pair's pulse.

A toggle is taken only when three conditions hold together:

- a trigger from the integrator is present, or one arrived earlier and is still pending;
- the minimum-period timer has cleared;
- the rectifiers have signalled turn-off, or the maximum-period timer has run out.

These rules keep the switching rate between a ceiling and a floor. The turn-off signal counts only after a first toggle has happened since rest. So after reset, and again after every inhibit, the sequencer restarts at its slowest rate. Once it is running, the integrator alone sets the rate.

Top module: `inv_fire_seq`

## Requirements
- R1: After reset, `phase` is 0 and every firing output is 0.
- R2: After a qualifying cycle, the new value of `phase` is valid from the next cycle. From that same cycle, `fire_p1` carries one pulse `PULSE_W` cycles long on the half given by the new `phase`: bit 0 when `phase` is 0, bit 1 when `phase` is 1.
- R3: `phase` inverts exactly once for each qualifying cycle and is otherwise held.
- R4: Two toggles are never less than `MIN_CYC` clock edges apart.
- R5: If the turn-off sense is low, or no toggle has happened since reset or inhibit, a toggle waits until `MAX_CYC` cycles have passed since the last toggle, reset or inhibit. After reset or inhibit the first toggle lands `MAX_CYC + 1` edges after the inhibit edge.
- R6: While running with turn-off sense high and the trigger held, toggles come every `MIN_CYC` edges.
- R7: A trigger that arrives before the conditions are met is kept pending and takes effect once they are met.
- R8: While `inhibit` is high, all firing outputs are 0 in the same cycle and `phase` holds. Inhibit drops the pending trigger and the running state, so the restart follows R5.
- R9: `fire_p2` equals `fire_p1` while `pair2_en` is 1 and is 0 otherwise.
- R10: Bits 0 and 1 of `fire_p1` are never 1 in the same cycle.
- R11: With no trigger, `phase` never changes, even after both timers have expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| integ_trig | input | 1 | Trigger from the volt-second integrator |
| off_sense | input | 1 | Rectifier turn-off confirmation |
| inhibit | input | 1 | Overload stop: suppresses firing and toggling |
| pair2_en | input | 1 | Enables the second rectifier pair |
| fire_p1 | output | 2 | Pair-one firing pulses, bit 0 half A, bit 1 half B |
| fire_p2 | output | 2 | Pair-two firing pulses, same bit order |
| phase | output | 1 | Toggle state and integrator switch select |

## Verification
The bench builds the block with `MIN_CYC` = 6, `MAX_CYC` = 20 and `PULSE_W` = 3. With these values the timeout path and the turn-off path give clearly different toggle spacings, and a full slow-start cycle takes only a few dozen cycles. The pulse is short enough to end well before the earliest possible next toggle. It is also long enough that an inhibit arriving during a pulse, or a change of `pair2_en` during a pulse, lands mid-pulse within reach of the random stimulus.

// File: rtl/inv_fire_pkg.sv
package inv_fire_pkg;

    // Which inverter half is currently selected
    typedef enum logic {
        HALF_A = 1'b0,
        HALF_B = 1'b1
    } half_e;

    // Timer status flags seen by the advance qualifier
    typedef struct packed {
        logic min_ok;   // shortest safe period has elapsed
        logic max_to;   // longest safe period has elapsed
    } per_stat_t;

    function automatic logic [1:0] half_mask(input half_e h);
        return (h == HALF_B) ? 2'b10 : 2'b01;
    endfunction

    function automatic half_e half_flip(input half_e h);
        return (h == HALF_A) ? HALF_B : HALF_A;
    endfunction

endpackage

// File: rtl/ifs_period_timer.sv
module ifs_period_timer
    import inv_fire_pkg::*;
#(
    parameter int MIN_CYC = 6,
    parameter int MAX_CYC = 20
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      restart,
    output per_stat_t stat
);
    localparam int CW = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] MIN_V = CW'(MIN_CYC);
    localparam logic [CW-1:0] MAX_V = CW'(MAX_CYC);

    logic [CW-1:0] cnt;

    // Counts cycles since the last toggle; 0 after rest, saturates at MAX.
    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (restart)
            cnt <= CW'(1);
        else if (cnt < MAX_V)
            cnt <= cnt + CW'(1);
    end

    always_comb begin
        stat.min_ok = (cnt >= MIN_V);
        stat.max_to = (cnt >= MAX_V);
    end

    AST_TMR_ORDER: assert property (@(posedge clk) disable iff (rst)
        stat.max_to |-> stat.min_ok)                                  // R4
        else $error("max timeout without min clearance");
endmodule

// File: rtl/ifs_advance_gate.sv
module ifs_advance_gate
    import inv_fire_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      inhibit,
    input  logic      trig,
    input  logic      sense,
    input  per_stat_t stat,
    output logic      advance
);
    logic pend_q;
    logic run_q;
    logic trig_any;
    logic release_ok;

    always_comb begin
        trig_any   = trig | pend_q;
        // turn-off sense counts only once the sequencer is running
        release_ok = (sense & run_q) | stat.max_to;
        advance    = trig_any & stat.min_ok & release_ok & ~inhibit;
    end

    always_ff @(posedge clk) begin
        if (rst || inhibit) begin
            pend_q <= 1'b0;
            run_q  <= 1'b0;
        end else if (advance) begin
            pend_q <= 1'b0;
            run_q  <= 1'b1;
        end else if (trig) begin
            pend_q <= 1'b1;
        end
    end

    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (rst)
        (trig && !advance && !inhibit) |=> pend_q)                    // R7
        else $error("trigger lost before qualification");
endmodule

// File: rtl/ifs_pulse_gen.sv
module ifs_pulse_gen
    import inv_fire_pkg::*;
#(
    parameter int PULSE_W = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       kill,
    input  logic       fire_now,
    input  half_e      half_in,
    output logic [1:0] fire
);
    localparam int PW = $clog2(PULSE_W + 1);

    logic [PW-1:0] left_q;
    half_e         half_q;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            left_q <= '0;
            half_q <= HALF_A;
        end else if (fire_now) begin
            left_q <= PW'(PULSE_W);
            half_q <= half_in;
        end else if (left_q != '0) begin
            left_q <= left_q - PW'(1);
        end
    end

    assign fire = ((left_q != '0) && !kill) ? half_mask(half_q) : 2'b00;

    AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
        (fire_now && !kill) |=> (fire != 2'b00) || kill)              // R2
        else $error("pulse did not start");
endmodule

// File: rtl/inv_fire_seq.sv
module inv_fire_seq
    import inv_fire_pkg::*;
#(
    parameter int MIN_CYC = 6,   // shortest period in cycles, >= 2
    parameter int MAX_CYC = 20,  // longest period in cycles, > MIN_CYC
    parameter int PULSE_W = 3    // firing pulse width, <= MIN_CYC
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       integ_trig,
    input  logic       off_sense,
    input  logic       inhibit,
    input  logic       pair2_en,
    output logic [1:0] fire_p1,
    output logic [1:0] fire_p2,
    output logic       phase
);
    localparam int GW = $clog2(MAX_CYC + 1);

    per_stat_t stat;
    logic      advance;
    half_e     phase_q;

    ifs_period_timer #(.MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (inhibit),
        .restart (advance),
        .stat    (stat)
    );

    ifs_advance_gate i_gate (
        .clk     (clk),
        .rst     (rst),
        .inhibit (inhibit),
        .trig    (integ_trig),
        .sense   (off_sense),
        .stat    (stat),
        .advance (advance)
    );

    ifs_pulse_gen #(.PULSE_W(PULSE_W)) i_pulse (
        .clk      (clk),
        .rst      (rst),
        .kill     (inhibit),
        .fire_now (advance),
        .half_in  (half_flip(phase_q)),
        .fire     (fire_p1)
    );

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= HALF_A;
        else if (advance)
            phase_q <= half_flip(phase_q);
    end

    assign phase   = phase_q;
    assign fire_p2 = pair2_en ? fire_p1 : 2'b00;

    // Independent spacing observer built from the phase output alone
    logic          ph_seen;
    logic [GW-1:0] gap;
    logic          fresh;
    logic          flipped;

    assign flipped = (phase != ph_seen);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_seen <= 1'b0;
            gap     <= '0;
            fresh   <= 1'b1;
        end else begin
            ph_seen <= phase;
            if (inhibit) begin
                gap   <= '0;
                fresh <= 1'b1;
            end else begin
                if (flipped)
                    gap <= GW'(2);
                else if (gap < GW'(MAX_CYC))
                    gap <= gap + GW'(1);
                if (flipped)
                    fresh <= 1'b0;
            end
        end
    end

    AST_MIN_GAP: assert property (@(posedge clk) disable iff (rst)
        flipped |-> ($past(gap) >= GW'(MIN_CYC)))                     // R4
        else $error("toggles closer than minimum period");

    AST_SLOW_START: assert property (@(posedge clk) disable iff (rst)
        (flipped && $past(fresh)) |-> ($past(gap) >= GW'(MAX_CYC)))   // R5
        else $error("first toggle after rest too early");

    AST_FLIP_PULSE: assert property (@(posedge clk) disable iff (rst)
        (flipped && !inhibit) |-> (fire_p1 == half_mask(phase_q)))    // R2
        else $error("toggle without pulse on new half");

    AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> $stable(phase))                                   // R8
        else $error("phase moved under inhibit");

    AST_HALF_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fire_p1))                                            // R10
        else $error("both halves fired");

    AST_PAIR2_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (fire_p2 != 2'b00) |-> (pair2_en && fire_p2 == fire_p1))      // R9
        else $error("second pair fired on its own");
endmodule

// File: tb/test_inv_fire_seq.sv
`timescale 1ns/1ps
module test_inv_fire_seq;
    localparam int MIN_CYC = 6;
    localparam int MAX_CYC = 20;
    localparam int PULSE_W = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       integ_trig = 1'b0;
    logic       off_sense = 1'b0;
    logic       inhibit = 1'b0;
    logic       pair2_en = 1'b0;
    logic [1:0] fire_p1;
    logic [1:0] fire_p2;
    logic       phase;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    inv_fire_seq #(.MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC), .PULSE_W(PULSE_W)) i_inv_fire_seq (
        .clk(clk), .rst(rst), .integ_trig(integ_trig), .off_sense(off_sense),
        .inhibit(inhibit), .pair2_en(pair2_en),
        .fire_p1(fire_p1), .fire_p2(fire_p2), .phase(phase)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Requirement-level reference state
    bit m_phase, m_pend, m_run;
    int m_cnt, m_pw;

    function automatic logic [1:0] exp_p1(input bit ph, input int pw, input bit inh);
        if (pw == 0 || inh) return 2'b00;
        return ph ? 2'b10 : 2'b01;
    endfunction

    function automatic bit qualifies(input int cnt, input bit trg, input bit pend,
                                     input bit sns, input bit run, input bit inh);
        return (trg || pend) && (cnt >= MIN_CYC) && ((sns && run) || cnt >= MAX_CYC) && !inh;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_pend = 0; m_run = 0; m_pw = 0;
        end else if (inhibit) begin
            m_cnt = 0; m_pend = 0; m_run = 0; m_pw = 0;
        end else if (qualifies(m_cnt, integ_trig, m_pend, off_sense, m_run, inhibit)) begin
            m_phase = !m_phase; m_cnt = 1; m_pend = 0; m_run = 1; m_pw = PULSE_W;
        end else begin
            if (m_cnt < MAX_CYC) m_cnt = m_cnt + 1;
            if (integ_trig) m_pend = 1;
            if (m_pw > 0) m_pw = m_pw - 1;
        end
        #1;
        if (!rst && !done) begin
            logic [1:0] e1;
            e1 = exp_p1(m_phase, m_pw, inhibit);
            chk(phase == m_phase, "R3 phase", phase, m_phase);
            chk(fire_p1 == e1, "R2 fire_p1", fire_p1, e1);
            chk(fire_p2 == (pair2_en ? e1 : 2'b00), "R9 fire_p2", fire_p2, pair2_en ? e1 : 2'b00);
            chk(fire_p1 != 2'b11, "R10 halves", fire_p1, 0);
        end
    end

    task automatic wait_flip(input int limit, output int n);
        logic p0;
        p0 = phase;
        n = 0;
        while (n <= limit) begin
            @(negedge clk);
            n++;
            if (phase != p0) break;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        logic p0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(phase == 1'b0, "R1 phase", phase, 0);
        chk(fire_p1 == 2'b00 && fire_p2 == 2'b00, "R1 fire", fire_p1, 0);

        // R11: timers expire, no trigger
        repeat (MAX_CYC + 5) @(negedge clk);
        chk(phase == 1'b0, "R11 no trigger", phase, 0);

        // R5: slow start ignores sense before first toggle
        inhibit = 1'b1;
        @(negedge clk);
        inhibit = 1'b0; integ_trig = 1'b1; off_sense = 1'b1;
        wait_flip(MAX_CYC + 10, n);
        chk(n == MAX_CYC + 1, "R5 slow start", n, MAX_CYC + 1);

        // R6: running with sense
        wait_flip(MAX_CYC + 10, n);
        chk(n == MIN_CYC, "R6 fast spacing", n, MIN_CYC);
        wait_flip(MAX_CYC + 10, n);
        chk(n == MIN_CYC, "R4 min spacing", n, MIN_CYC);

        // R5: no sense -> timeout spacing
        off_sense = 1'b0;
        wait_flip(MAX_CYC + 10, n);
        chk(n == MAX_CYC, "R5 timeout spacing", n, MAX_CYC);

        // R7: early one-cycle trigger kept pending
        off_sense = 1'b1;
        @(negedge clk);
        integ_trig = 1'b0;
        wait_flip(MAX_CYC + 10, n);
        chk(n == MIN_CYC - 1, "R7 pending trigger", n, MIN_CYC - 1);
        p0 = phase;
        repeat (MAX_CYC + 3) @(negedge clk);
        chk(phase == p0, "R11 trigger consumed", phase, p0);

        // R9: second pair
        integ_trig = 1'b1; pair2_en = 1'b1;
        wait_flip(MAX_CYC + 10, n);
        chk(fire_p2 == fire_p1 && fire_p1 != 2'b00, "R9 pair2 on", fire_p2, fire_p1);
        pair2_en = 1'b0;
        wait_flip(MAX_CYC + 10, n);
        chk(fire_p2 == 2'b00 && fire_p1 != 2'b00, "R9 pair2 off", fire_p2, 0);

        // R8: inhibit freezes and restarts slowly
        inhibit = 1'b1;
        p0 = phase;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(fire_p1 == 2'b00 && phase == p0, "R8 inhibit hold", fire_p1, 0);
        end
        inhibit = 1'b0;
        wait_flip(MAX_CYC + 10, n);
        chk(n == MAX_CYC + 1, "R8 restart slow", n, MAX_CYC + 1);

        // Random phase, checked by the reference each cycle
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            integ_trig = ($urandom % 4) == 0;
            off_sense  = ($urandom % 3) != 0;
            inhibit    = ($urandom % 97) == 0;
            pair2_en   = ($urandom % 2) == 1;
        end
        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule